// File: doc/BRIEF.md
# Time-Multiplexed Open-Collector I/O Port

This block shares one narrow open-collector port between two output banks. A phase signal selects the bank. While the phase is low the low bank sits on the pads, and while it is high the high bank does. A 1 in an output bit turns on that pad's pull-down, so the pad reads 0 V. A 0 releases the pad, and the external pull-up takes it high. Two external edge-triggered latches take the port value: the low bank on the rising edge of the phase signal and the high bank on the falling edge. The block keeps the pad drive still across both edges.

During each phase the block also reads back the shared port and a separate input-only port. A pad at 0 V reads as logic 1, whether this block or an outside device pulled it down. The shared-port readback is therefore the OR of the driven word and the external inputs. A port bit serves as an input when its output bit is 0. Each phase runs in a fixed order: drive, wait a programmable settle count, sample, hold, then toggle the phase. Two configuration bits select single-bank operation and enable the shared-port readback.

Top module: `mux_oc_port`

## Requirements
- R1: After reset, the phase output, all pad pull-down enables and all three captured words are 0.
- R2: During the low phase, the pull-down enables equal the low output bank, bit for bit, with 1 meaning the pad is pulled to 0 V.
- R3: During the high phase, the pull-down enables equal the high output bank.
- R4: The pull-down enables never change on the same clock edge as the phase output, so the external latch sees the low bank at the rising phase edge and the high bank at the falling phase edge.
- R5: In the low phase, the low captured word is set to the inverse of the shared-port pad levels, which is the OR of the driven low bank and the external pull-downs.
- R6: In the high phase, the high captured word is set to the inverse of the shared-port pad levels, which is the OR of the driven high bank and the external pull-downs.
- R7: In every phase, the input-port captured word is set to the inverse of the input-port pad levels.
- R8: A phase lasts settle+3 clock cycles: one drive cycle, settle wait cycles, one sample cycle and one hold cycle. A settle value of 0 gives 3 cycles.
- R9: While single-bank select is 1, the phase output stays low. Only the low bank is driven and sampled, and the high captured word keeps its value.
- R10: While the readback enable is 0, each sample writes 0 into the low or high captured word. The input-port word is still sampled.
- R11: An output bit of 0 releases its pad, so an external pull-down on that pad is captured as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_lo_i | input | WIDTH | Low output bank, placed on the port in the low phase |
| out_hi_i | input | WIDTH | High output bank, placed on the port in the high phase |
| port_pad_i | input | WIDTH | Voltage level of the shared port pads (1 = high) |
| in_pad_i | input | WIDTH | Voltage level of the input-only port pads (1 = high) |
| cfg_bidir_i | input | 1 | 1 enables shared-port readback |
| cfg_single_i | input | 1 | 1 selects single-bank operation |
| settle_i | input | CNT_W | Settle wait length in cycles |
| pad_pd_o | output | WIDTH | Pad pull-down enables (1 = pull pad to 0 V) |
| mux_o | output | 1 | Phase signal (0 = low bank, 1 = high bank) |
| din_lo_o | output | WIDTH | Shared-port word captured in the low phase |
| din_hi_o | output | WIDTH | Shared-port word captured in the high phase |
| din_in_o | output | WIDTH | Input-port word captured in every phase |

## Verification
The bench builds the block with WIDTH of 8 and CNT_W of 4. It models the wired-OR pads and the two phase-edge latches around the block. With a 4-bit settle field, both extremes of the settle count can be measured directly: 0 gives 3-cycle phases and 15 gives 18-cycle phases. The byte-wide port lets the stimulus patterns set drive and external pull-down bits against each other on every pad position.

// File: rtl/mux_oc_pkg.sv
package mux_oc_pkg;
   typedef enum logic [1:0] {
      PH_DRIVE  = 2'd0,
      PH_SETTLE = 2'd1,
      PH_SAMPLE = 2'd2,
      PH_HOLD   = 2'd3
   } ph_state_e;
endpackage

// File: rtl/mux_oc_seq.sv
module mux_oc_seq
   import mux_oc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] settle_i,
   input  logic             single_i,
   output logic             mux_o,
   output logic             drive_o,
   output logic             sample_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   ph_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             mux_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_DRIVE;
         cnt_q   <= '0;
         mux_q   <= 1'b0;
      end else begin
         case (state_q)
            PH_DRIVE: begin
               if (settle_i == '0) begin
                  state_q <= PH_SAMPLE;
               end else begin
                  cnt_q   <= settle_i;
                  state_q <= PH_SETTLE;
               end
            end
            PH_SETTLE: begin
               if (cnt_q <= CNT_ONE) state_q <= PH_SAMPLE;
               else                  cnt_q   <= cnt_q - CNT_ONE;
            end
            PH_SAMPLE: state_q <= PH_HOLD;
            default: begin
               mux_q   <= single_i ? 1'b0 : ~mux_q;
               state_q <= PH_DRIVE;
            end
         endcase
      end
   end

   assign mux_o    = mux_q;
   assign drive_o  = (state_q == PH_DRIVE);
   assign sample_o = (state_q == PH_SAMPLE);
endmodule

// File: rtl/mux_oc_drive.sv
module mux_oc_drive #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drive_i,
   input  logic             mux_i,
   input  logic [WIDTH-1:0] out_lo_i,
   input  logic [WIDTH-1:0] out_hi_i,
   output logic [WIDTH-1:0] pad_pd_o
);
   logic [WIDTH-1:0] pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pd_q <= '0;
      else if (drive_i) pd_q <= mux_i ? out_hi_i : out_lo_i;
   end

   assign pad_pd_o = pd_q;
endmodule

// File: rtl/mux_oc_capture.sv
module mux_oc_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_i,
   input  logic             mux_i,
   input  logic             bidir_i,
   input  logic [WIDTH-1:0] port_pad_i,
   input  logic [WIDTH-1:0] in_pad_i,
   output logic [WIDTH-1:0] din_lo_o,
   output logic [WIDTH-1:0] din_hi_o,
   output logic [WIDTH-1:0] din_in_o
);
   logic [WIDTH-1:0] lo_q, hi_q, in_q;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic rd_port;
      assign rd_port = bidir_i & ~port_pad_i[b];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[b] <= 1'b0;
            hi_q[b] <= 1'b0;
            in_q[b] <= 1'b0;
         end else if (sample_i) begin
            in_q[b] <= ~in_pad_i[b];
            if (mux_i) hi_q[b] <= rd_port;
            else       lo_q[b] <= rd_port;
         end
      end
   end

   assign din_lo_o = lo_q;
   assign din_hi_o = hi_q;
   assign din_in_o = in_q;
endmodule

// File: rtl/mux_oc_port.sv
module mux_oc_port #(
   parameter int WIDTH = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] out_lo_i,
   input  logic [WIDTH-1:0] out_hi_i,
   input  logic [WIDTH-1:0] port_pad_i,
   input  logic [WIDTH-1:0] in_pad_i,
   input  logic             cfg_bidir_i,
   input  logic             cfg_single_i,
   input  logic [CNT_W-1:0] settle_i,
   output logic [WIDTH-1:0] pad_pd_o,
   output logic             mux_o,
   output logic [WIDTH-1:0] din_lo_o,
   output logic [WIDTH-1:0] din_hi_o,
   output logic [WIDTH-1:0] din_in_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("mux_oc_port: WIDTH must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("mux_oc_port: CNT_W must be at least 1");
   end

   logic drive_w, sample_w, mux_w;

   mux_oc_seq #(.CNT_W(CNT_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .settle_i(settle_i), .single_i(cfg_single_i),
      .mux_o(mux_w), .drive_o(drive_w), .sample_o(sample_w)
   );

   mux_oc_drive #(.WIDTH(WIDTH)) i_drive (
      .clk(clk), .rst_n(rst_n), .drive_i(drive_w), .mux_i(mux_w),
      .out_lo_i(out_lo_i), .out_hi_i(out_hi_i), .pad_pd_o(pad_pd_o)
   );

   mux_oc_capture #(.WIDTH(WIDTH)) i_cap (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_w), .mux_i(mux_w),
      .bidir_i(cfg_bidir_i), .port_pad_i(port_pad_i), .in_pad_i(in_pad_i),
      .din_lo_o(din_lo_o), .din_hi_o(din_hi_o), .din_in_o(din_in_o)
   );

   assign mux_o = mux_w;
endmodule

// File: rtl/mux_oc_port_chk.sv
module mux_oc_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mux_o,
   input logic [WIDTH-1:0] pad_pd_o,
   input logic [WIDTH-1:0] out_lo_i,
   input logic [WIDTH-1:0] out_hi_i,
   input logic             cfg_single_i,
   input logic             cfg_bidir_i,
   input logic [WIDTH-1:0] din_lo_o,
   input logic [WIDTH-1:0] din_hi_o
);
   // R4
   pad_still_at_phase_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mux_o) |-> $stable(pad_pd_o));

   // R2 R3
   pad_follows_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pad_pd_o) |-> (pad_pd_o == (mux_o ? $past(out_hi_i) : $past(out_lo_i))));

   // R8
   phase_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mux_o) |=> $stable(mux_o));

   // R9
   single_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_single_i |=> !$rose(mux_o));

   // R10
   no_readback_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(din_lo_o) && !$past(cfg_bidir_i)) |-> (din_lo_o == '0));

   // R10
   no_readback_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(din_hi_o) && !$past(cfg_bidir_i)) |-> (din_hi_o == '0));
endmodule

bind mux_oc_port mux_oc_port_chk #(.WIDTH(WIDTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .mux_o(mux_o), .pad_pd_o(pad_pd_o),
   .out_lo_i(out_lo_i), .out_hi_i(out_hi_i), .cfg_single_i(cfg_single_i),
   .cfg_bidir_i(cfg_bidir_i), .din_lo_o(din_lo_o), .din_hi_o(din_hi_o)
);

// File: tb/test_mux_oc_port.sv
`timescale 1ns/1ps
module test_mux_oc_port;
   localparam int WIDTH = 8;
   localparam int CNT_W = 4;
   localparam int NVEC  = 6;

   // {out_lo, out_hi, ext_port, ext_in, exp_lo, exp_hi, exp_in}
   localparam logic [55:0] VEC [NVEC] = '{
      56'h00_00_00_00_00_00_00,
      56'hA5_3C_00_FF_A5_3C_FF,
      56'h00_00_81_0F_81_81_0F,
      56'hF0_0F_11_5A_F1_1F_5A,
      56'hFF_00_00_00_FF_00_00,
      56'h12_C0_24_80_36_E4_80
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [WIDTH-1:0] out_lo = '0, out_hi = '0, ext_port = '0, ext_in = '0;
   logic             cfg_bidir = 1'b1, cfg_single = 1'b0;
   logic [CNT_W-1:0] settle = 4'd2;
   logic [WIDTH-1:0] pad_pd, din_lo, din_hi, din_in, port_pad, in_pad;
   logic [WIDTH-1:0] lat_lo = '0, lat_hi = '0;
   logic             mux;
   int               errors = 0, checks = 0;

   always #5 clk = ~clk;

   assign port_pad = ~(pad_pd | ext_port);
   assign in_pad   = ~ext_in;

   always @(posedge mux) lat_lo <= pad_pd;
   always @(negedge mux) lat_hi <= pad_pd;

   mux_oc_port #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_mux_oc_port (
      .clk(clk), .rst_n(rst_n), .out_lo_i(out_lo), .out_hi_i(out_hi),
      .port_pad_i(port_pad), .in_pad_i(in_pad), .cfg_bidir_i(cfg_bidir),
      .cfg_single_i(cfg_single), .settle_i(settle), .pad_pd_o(pad_pd),
      .mux_o(mux), .din_lo_o(din_lo), .din_hi_o(din_hi), .din_in_o(din_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic two_rounds();
      @(posedge mux);
      @(posedge mux);
      #1;
   endtask

   task automatic measure(input int n);
      realtime t0;
      settle = n[CNT_W-1:0];
      two_rounds();
      @(negedge mux);
      t0 = $realtime;
      @(posedge mux);
      chk("R8 phase length", int'(($realtime - t0) / 10.0), n + 3);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [WIDTH-1:0] hold_hi;
      int highs;
      #23;
      // R1 reset state
      chk("R1 mux", mux, 0);
      chk("R1 pad", pad_pd, 0);
      chk("R1 din_lo", din_lo, 0);
      chk("R1 din_hi", din_hi, 0);
      chk("R1 din_in", din_in, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         out_lo   = VEC[i][55:48];
         out_hi   = VEC[i][47:40];
         ext_port = VEC[i][39:32];
         ext_in   = VEC[i][31:24];
         two_rounds();
         chk("R2 R4 latch at rise", lat_lo, VEC[i][55:48]);
         chk("R3 R4 latch at fall", lat_hi, VEC[i][47:40]);
         chk("R5 R11 din_lo", din_lo, VEC[i][23:16]);
         chk("R6 R11 din_hi", din_hi, VEC[i][15:8]);
         chk("R7 din_in", din_in, VEC[i][7:0]);
      end

      measure(0);
      measure(5);
      measure(15);
      settle = 4'd1;

      // R9 single bank
      out_lo = 8'h55; out_hi = 8'hFF; ext_port = 8'h00; ext_in = 8'h3C;
      two_rounds();
      hold_hi = din_hi;
      cfg_single = 1'b1;
      @(negedge mux);
      highs = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (mux) highs++;
      end
      chk("R9 mux stays low", highs, 0);
      chk("R9 pad low bank", pad_pd, 8'h55);
      chk("R9 din_lo", din_lo, 8'h55);
      chk("R9 din_hi kept", din_hi, hold_hi);
      chk("R9 din_in", din_in, 8'h3C);
      cfg_single = 1'b0;

      // R10 readback disabled
      cfg_bidir = 1'b0;
      ext_port = 8'hF0; ext_in = 8'h0F;
      two_rounds();
      chk("R10 din_lo zero", din_lo, 0);
      chk("R10 din_hi zero", din_hi, 0);
      chk("R10 din_in still sampled", din_in, 8'h0F);
      chk("R10 R2 latch", lat_lo, 8'h55);
      cfg_bidir = 1'b1;
      two_rounds();
      chk("R5 readback restored", din_lo, 8'hF5);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 re-reset pad", pad_pd, 0);
      chk("R1 re-reset din_lo", din_lo, 0);
      chk("R1 re-reset mux", mux, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule